// File: doc/BRIEF.md
# I2C SCL Clock Divider with Standard and Fast Timing

This block derives the SCL waveform of an I2C master from the system clock. It takes a 12-bit divider N and a mode bit from two 8-bit configuration registers. It then produces a low-phase enable and a high-phase enable, together with two single-cycle strobes. The bus engine uses those strobes to change SDA in the middle of the low phase and to sample SDA in the middle of the high phase. Standard and fast timing map N to the period through two different affine formulas. In fast timing the low phase takes about two thirds of the period. In standard timing the period is split about evenly.

Each period starts with its low phase. The divider and mode are copied into an active copy on every cycle while the block is idle, and otherwise only on the last cycle of a period. A change written in the middle of a period therefore never distorts the period under way. A divider below 2 is refused: the block flags it and holds SCL released (high) with no strobes.

Top module: `i2c_scl_divider`

## Requirements
- R1: During and right after reset, scl_high is 1, scl_low is 0, both strobes are 0, and div_bad is 1, because the active divider resets to 0 until the first load.
- R2: The divider is N = {ext_reg[4:0], ctrl_reg[6:0]}, with ext_reg[4:0] as bits 11..7. ctrl_reg[7] = 1 selects fast timing and 0 selects standard timing. ext_reg[7:5] are ignored.
- R3: In standard timing, one SCL period is 2N+5 clocks: N+3 clocks low followed by N+2 clocks high.
- R4: In fast timing, one SCL period is 3N+6 clocks: 2N+4 clocks low followed by N+2 clocks high.
- R5: change_stb is high for exactly one clock per period, at offset floor(low/2) from the period start, and only while scl_low is 1. It is never high together with sample_stb.
- R6: sample_stb is high for exactly one clock per period, at offset low + floor(high/2), and only while scl_high is 1.
- R7: When N < 2, div_bad is 1, scl_high stays 1 and no strobe fires, even with run high. div_bad tracks the loaded value one clock after a change made while idle.
- R8: While run is 0, SCL is idle: scl_high is 1, scl_low is 0 and there are no strobes. Dropping run mid-period idles SCL in the same cycle. The first cycle with run high and a valid divider is cycle 0 of a fresh period, so scl_low is 1.
- R9: A mode or divider change made during a running period leaves that period's timing unchanged. It takes effect from the next period onward.
- R10: The full 12-bit range is honoured up to N = 4095. In fast timing, N = 4095 gives a low phase of 8194 clocks and a high phase of 4097 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Request from the bus engine to clock SCL |
| ctrl_reg | input | 8 | Bit 7 selects fast mode; bits 6..0 are divider bits 6..0 |
| ext_reg | input | 8 | Bits 4..0 are divider bits 11..7; bits 7..5 are ignored |
| scl_high | output | 1 | SCL high-phase enable (also 1 when idle) |
| scl_low | output | 1 | SCL low-phase enable |
| sample_stb | output | 1 | One-clock strobe in the middle of the high phase |
| change_stb | output | 1 | One-clock strobe in the middle of the low phase |
| div_bad | output | 1 | Active divider is below 2 |

## Verification
The bench measures whole periods, clock by clock, in both modes. It uses the smallest legal divider, a divider that needs the extended register bits, and the largest divider. A design that swapped the two formulas, dropped the upper register, or mis-split the phases would show a wrong low or high length, or a strobe in the wrong cycle. It changes the configuration in the middle of a running period, and applies dividers of 0 and 1. A design that loaded the new value at once would shorten or stretch the current period, and one without the lower bound would toggle SCL at a runaway rate. It also drops and restores run mid-period. A design that resumed its old count, instead of starting a fresh low phase, would be caught there.

// File: rtl/i2c_scl_divider.sv
module i2c_scl_divider #(
  parameter int DIV_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [7:0] ctrl_reg,
  input  logic [7:0] ext_reg,
  output logic       scl_high,
  output logic       scl_low,
  output logic       sample_stb,
  output logic       change_stb,
  output logic       div_bad
);
  localparam int LO_W  = 7;
  localparam int HI_W  = DIV_W - LO_W;
  localparam int CNT_W = $clog2(3 * (1 << DIV_W) + 7);

  logic             fast_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt;

  logic [CNT_W-1:0] n, hi_len, lo_len, per, chg_pt, smp_pt;
  logic             active, last, load;

  assign n      = CNT_W'(div_q);
  assign hi_len = n + CNT_W'(2);
  assign lo_len = fast_q ? (n << 1) + CNT_W'(4) : n + CNT_W'(3);
  assign per    = lo_len + hi_len;
  assign chg_pt = lo_len >> 1;
  assign smp_pt = lo_len + (hi_len >> 1);

  assign div_bad = div_q < DIV_W'(2);
  assign active  = run && !div_bad;
  assign last    = cnt == per - CNT_W'(1);
  assign load    = !active || last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= 1'b0;
      div_q  <= '0;
      cnt    <= '0;
    end else begin
      if (load) begin
        fast_q <= ctrl_reg[7];
        div_q  <= {ext_reg[HI_W-1:0], ctrl_reg[LO_W-1:0]};
      end
      if (!active || last) cnt <= '0;
      else                 cnt <= cnt + CNT_W'(1);
    end
  end

  assign scl_low    = active && (cnt < lo_len);
  assign scl_high   = !scl_low;
  assign change_stb = active && (cnt == chg_pt);
  assign sample_stb = active && (cnt == smp_pt);
endmodule

module i2c_scl_divider_chk #(
  parameter int DIV_W = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic [7:0] ctrl_reg,
  input logic [7:0] ext_reg,
  input logic       scl_high,
  input logic       scl_low,
  input logic       sample_stb,
  input logic       change_stb,
  input logic       div_bad
);
  localparam int HI_W = DIV_W - 7;

  AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (scl_high && !scl_low && !sample_stb && !change_stb)); // R8
  AST_IDLE_WHEN_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    div_bad |-> (scl_high && !sample_stb && !change_stb)); // R7
  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_stb, change_stb})); // R5
  AST_CHANGE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    change_stb |-> scl_low); // R5
  AST_SAMPLE_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> scl_high); // R6
  AST_FRESH_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run) && !div_bad) |-> scl_low); // R8
  AST_BAD_TRACKS_IDLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (div_bad == ({$past(ext_reg[HI_W-1:0]), $past(ctrl_reg[6:0])} < DIV_W'(2)))); // R7
endmodule

bind i2c_scl_divider i2c_scl_divider_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .ctrl_reg(ctrl_reg), .ext_reg(ext_reg),
  .scl_high(scl_high), .scl_low(scl_low), .sample_stb(sample_stb),
  .change_stb(change_stb), .div_bad(div_bad)
);

// File: tb/i2c_scl_divider_test.sv
module i2c_scl_divider_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [7:0] ctrl_reg = 8'h00;
  logic [7:0] ext_reg = 8'h00;
  logic scl_high, scl_low, sample_stb, change_stb, div_bad;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_scl_divider uut (
    .clk(clk), .rst_n(rst_n), .run(run), .ctrl_reg(ctrl_reg), .ext_reg(ext_reg),
    .scl_high(scl_high), .scl_low(scl_low), .sample_stb(sample_stb),
    .change_stb(change_stb), .div_bad(div_bad)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic start(input logic [7:0] c, input logic [7:0] e);
    step();
    run = 1'b0; ctrl_reg = c; ext_reg = e;
    step();
    run = 1'b1;
    #1;
  endtask

  // Walks one period from its cycle 0; returns at cycle 0 of the next one.
  task automatic check_period(input int lo, input int hi, input string req,
                              input int chg_at, input logic [7:0] nc, input logic [7:0] ne);
    int bad_low = -1, chg_cnt = 0, smp_cnt = 0, chg_pos = -1, smp_pos = -1;
    for (int i = 0; i < lo + hi; i++) begin
      if (scl_low != (i < lo) || scl_high == scl_low) if (bad_low < 0) bad_low = i;
      if (change_stb) begin chg_cnt++; chg_pos = i; end
      if (sample_stb) begin smp_cnt++; smp_pos = i; end
      if (i == chg_at) begin ctrl_reg = nc; ext_reg = ne; end
      step();
    end
    chk(bad_low < 0, {req, " phase shape"}, bad_low, -1);
    chk(chg_cnt == 1 && chg_pos == lo / 2, {req, " R5 change_stb offset"}, chg_pos, lo / 2);
    chk(smp_cnt == 1 && smp_pos == lo + hi / 2, {req, " R6 sample_stb offset"}, smp_pos, lo + hi / 2);
    chk(div_bad == 1'b0, {req, " div_bad"}, div_bad, 0);
  endtask

  task automatic t_reset();
    #1;
    chk(scl_high == 1'b1 && scl_low == 1'b0, "R1 idle SCL in reset", scl_low, 0);
    chk(!sample_stb && !change_stb, "R1 no strobes in reset", sample_stb | change_stb, 0);
    chk(div_bad == 1'b1, "R1 div_bad in reset", div_bad, 1);
    rst_n = 1'b1;
    step();
    chk(scl_high == 1'b1 && !sample_stb && !change_stb, "R1 idle after reset", scl_high, 1);
  endtask

  task automatic t_std_min();
    start(8'h02, 8'h00);
    check_period(5, 4, "R3 std N=2", -1, 8'h02, 8'h00);
    check_period(5, 4, "R3 std N=2 second", -1, 8'h02, 8'h00);
    run = 1'b0;
  endtask

  task automatic t_fast_min();
    start(8'h82, 8'h00);
    check_period(8, 4, "R4 fast N=2", -1, 8'h82, 8'h00);
    check_period(8, 4, "R4 fast N=2 second", -1, 8'h82, 8'h00);
    run = 1'b0;
  endtask

  task automatic t_split_reg();
    // N = {5'h01, 7'h05} = 133; ext upper bits set must be ignored
    start(8'h05, 8'hE1);
    check_period(136, 135, "R2 std N=133 split", -1, 8'h05, 8'hE1);
    run = 1'b0;
    start(8'h85, 8'hE1);
    check_period(270, 135, "R2 fast N=133 split", -1, 8'h85, 8'hE1);
    run = 1'b0;
  endtask

  task automatic t_max();
    start(8'hFF, 8'h1F);
    check_period(8194, 4097, "R10 fast N=4095", -1, 8'hFF, 8'h1F);
    run = 1'b0;
  endtask

  task automatic t_bad();
    int seen;
    for (int v = 0; v < 2; v++) begin
      start(8'h80 | 8'(v), 8'h00);
      seen = 0;
      for (int i = 0; i < 40; i++) begin
        if (!scl_high || scl_low || sample_stb || change_stb) seen++;
        step();
      end
      chk(seen == 0, "R7 bad divider holds SCL idle", seen, 0);
      chk(div_bad == 1'b1, "R7 div_bad for N<2", div_bad, 1);
      run = 1'b0;
    end
    ctrl_reg = 8'h02;
    step();
    chk(div_bad == 1'b0, "R7 div_bad clears after valid load", div_bad, 0);
    ctrl_reg = 8'h01;
    step();
    chk(div_bad == 1'b1, "R7 div_bad sets after invalid load", div_bad, 1);
  endtask

  task automatic t_midchange();
    start(8'h02, 8'h00);
    check_period(5, 4, "R9 current std period kept", 3, 8'h83, 8'h00);
    check_period(10, 5, "R9 next period fast N=3", -1, 8'h83, 8'h00);
    run = 1'b0;
  endtask

  task automatic t_run_drop();
    start(8'h02, 8'h00);
    step(); step(); step();
    run = 1'b0;
    #1;
    chk(scl_high == 1'b1 && scl_low == 1'b0, "R8 drop run idles SCL at once", scl_low, 0);
    step(); step();
    chk(scl_high == 1'b1 && !change_stb && !sample_stb, "R8 stays idle", scl_high, 1);
    run = 1'b1;
    #1;
    chk(scl_low == 1'b1, "R8 restart begins low", scl_low, 1);
    check_period(5, 4, "R8 fresh period after restart", -1, 8'h02, 8'h00);
    run = 1'b0;
  endtask

  initial begin
    t_reset();
    t_std_min();
    t_fast_min();
    t_split_reg();
    t_max();
    t_bad();
    t_midchange();
    t_run_drop();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule